// File: doc/BRIEF.md
# Packed Page-Table Entry Writer

This block fills a run of translation entries in a page table whose entries are 27-bit page frame numbers packed four to a 128-bit group of four 32-bit words. A run is given by a first entry index, an entry count and an address source. Each entry holds a physical address shifted right by 12, so the page size is 4 KiB. In linear mode the first address comes from a base input and each later entry is one page above the one before. In stream mode the addresses arrive one per entry on a valid/ready input. An unmap run instead clears the entries.

Because entries cross word boundaries, a group that the run covers only in part is read in full, the covered slots are replaced, and all four words are written back. Aligned groups that the run covers completely are written with no read. Every group written back with content has a marker bit set in its last word. Table memory is reached through one 32-bit word port with a request/acknowledge handshake. A one-cycle done pulse ends each run.

Top module: `pte_pack_writer`

## Requirements
- R1: Within a group, taken as the 128-bit value {word3, word2, word1, word0}, slot s holds its frame number at bits [27s+26:27s]. So slot 1 is split as word0[31:27] (low 5 bits) and word1[21:0], slot 2 as word1[31:22] and word2[16:0], and slot 3 as word2[31:17] and word3[11:0]. The frame number is address bits [38:12].
- R2: Every group written with content has word3 bit 30 set to 1. A group cleared by unmap is written as four zero words.
- R3: A group that the run covers only in part is read as words 0,1,2,3, then written as words 0,1,2,3. Slots outside the run keep their old bits, and so does the rest of the group, apart from the marker.
- R4: A mapping run writes an aligned group of four covered entries with no read. The bits of that group outside the four slots become zero, apart from the marker.
- R5: An unmap run writes the frame number of the dummy address input into the covered slots of partial groups. An aligned whole group becomes four zero words only when more than four entries remain. A final exactly-four group goes through R3 with the dummy address.
- R6: In linear mode, entry k of the run (k counted from 0) maps address base + k*0x1000.
- R7: In stream mode, one address is taken per entry, in entry order, on a cycle with src_valid and src_ready both high. src_ready is only high while the block waits for an entry address.
- R8: A count of zero gives a done pulse in the cycle after start, with no memory request.
- R9: done is high for exactly one cycle, in the cycle after the last write is acknowledged. busy is high from the start to the end of done. start is only accepted while busy is low.
- R10: While mem_req is high and mem_ack is low, the request address, direction and write data stay unchanged.
- R11: Word w of the group that holds entry i has byte address (i*4 with bits [3:0] cleared) + 4w. Each group access covers words 0 to 3 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (taken while idle) |
| unmap | input | 1 | Run clears entries instead of mapping |
| stream_mode | input | 1 | Addresses come from the src_* handshake |
| first_idx | input | IDX_W | First entry index |
| count | input | CNT_W | Number of entries |
| lin_base | input | PA_W | Physical address of the first entry in linear mode |
| dummy_addr | input | PA_W | Physical address written on unmap |
| src_valid | input | 1 | Stream address valid |
| src_addr | input | PA_W | Stream physical address |
| src_ready | output | 1 | Stream address taken |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | IDX_W+2 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request acknowledged; read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions check these rules on every cycle: the request stays stable while it waits for acknowledge, the four words of a group are accessed in order at one group address, the marker is set in every last word that is not all zero, no fill step overlaps a request, and done lasts one cycle. The bench's own scenarios are the only way to show the rest: the slot bit positions, that untouched slots survive a read-modify-write, the linear address step, the order of stream addresses, and which groups take the zero path or the read path on unmap. For those it compares the table memory and the read and write counts against a model built from the requirements.

// File: rtl/pte_pack_writer.sv
module pte_pack_writer #(
  parameter int IDX_W   = 17,
  parameter int CNT_W   = 18,
  parameter int PA_W    = 40,
  parameter int PFN_W   = 27,
  parameter int PAGE_SH = 12,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              unmap,
  input  logic              stream_mode,
  input  logic [IDX_W-1:0]  first_idx,
  input  logic [CNT_W-1:0]  count,
  input  logic [PA_W-1:0]   lin_base,
  input  logic [PA_W-1:0]   dummy_addr,
  input  logic              src_valid,
  input  logic [PA_W-1:0]   src_addr,
  output logic              src_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done
);
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RD, S_FILL, S_WR, S_FIN} st_t;

  localparam logic [PA_W-1:0] PAGE_STEP = PA_W'(1) << PAGE_SH;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-3:0] gbase;
  logic [CNT_W-1:0] rem;
  logic [1:0]       slot, last, wsel;
  logic             zero_grp, unmap_r, strm_r;
  logic [PA_W-1:0]  cur, dummy_r;
  logic [127:0]     grp;

  logic [1:0]       lo;
  logic [2:0]       room, take;
  logic             full;
  logic [PFN_W-1:0] pfn_now;
  logic             fill_go;

  assign lo      = idx[1:0];
  assign room    = 3'd4 - {1'b0, lo};
  assign take    = (rem < CNT_W'(room)) ? rem[2:0] : room;
  assign full    = (lo == 2'd0) && (unmap_r ? (rem > CNT_W'(4)) : (rem >= CNT_W'(4)));
  assign pfn_now = unmap_r ? dummy_r[PAGE_SH +: PFN_W]
                 : strm_r  ? src_addr[PAGE_SH +: PFN_W]
                 :           cur[PAGE_SH +: PFN_W];
  assign fill_go = (st == S_FILL) && (unmap_r || !strm_r || src_valid);

  assign src_ready = (st == S_FILL) && strm_r && !unmap_r;
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = {gbase, wsel, 2'b00};
  assign mem_wdata = grp[32*wsel +: 32] |
                     (((wsel == 2'd3) && !zero_grp) ? 32'h4000_0000 : 32'h0);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      gbase    <= '0;
      rem      <= '0;
      slot     <= '0;
      last     <= '0;
      wsel     <= '0;
      zero_grp <= 1'b0;
      unmap_r  <= 1'b0;
      strm_r   <= 1'b0;
      cur      <= '0;
      dummy_r  <= '0;
      grp      <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          idx     <= first_idx;
          rem     <= count;
          cur     <= lin_base;
          dummy_r <= dummy_addr;
          unmap_r <= unmap;
          strm_r  <= stream_mode;
          st      <= (count == '0) ? S_FIN : S_SETUP;
        end
        S_SETUP: begin
          gbase    <= idx[IDX_W-1:2];
          slot     <= lo;
          last     <= lo + take[1:0] - 2'd1;
          wsel     <= 2'd0;
          zero_grp <= 1'b0;
          if (full && unmap_r) begin
            grp      <= '0;
            zero_grp <= 1'b1;
            idx      <= idx + IDX_W'(4);
            rem      <= rem - CNT_W'(4);
            st       <= S_WR;
          end else if (full) begin
            grp <= '0;
            st  <= S_FILL;
          end else begin
            st  <= S_RD;
          end
        end
        S_RD: if (mem_ack) begin
          grp[32*wsel +: 32] <= mem_rdata;
          wsel <= wsel + 2'd1;
          if (wsel == 2'd3) st <= S_FILL;
        end
        S_FILL: if (fill_go) begin
          grp[PFN_W*slot +: PFN_W] <= pfn_now;
          slot <= slot + 2'd1;
          idx  <= idx + IDX_W'(1);
          rem  <= rem - CNT_W'(1);
          cur  <= cur + PAGE_STEP;
          if (slot == last) begin
            wsel <= 2'd0;
            st   <= S_WR;
          end
        end
        S_WR: if (mem_ack) begin
          wsel <= wsel + 2'd1;
          if (wsel == 2'd3) st <= (rem == '0) ? S_FIN : S_SETUP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pte_pack_writer_chk.sv
module pte_pack_writer_chk #(
  parameter int IDX_W = 17,
  localparam int ADDR_W = IDX_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              busy,
  input logic              done
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !src_ready)); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10

  AST_MARKER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[3:2] == 2'd3) |-> (mem_wdata[30] || mem_wdata == 32'h0)); // R2

  AST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_addr[3:2] != 2'd3) |=>
      (mem_req && mem_addr[3:2] == 2'($past(mem_addr[3:2]) + 2'd1) &&
       mem_addr[ADDR_W-1:4] == $past(mem_addr[ADDR_W-1:4]) && mem_we == $past(mem_we))); // R11

  AST_READ_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we && mem_addr[3:2] == 2'd3) |=> !mem_req); // R3

  AST_READY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> !mem_req); // R7
endmodule

bind pte_pack_writer pte_pack_writer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .busy(busy), .done(done));

// File: tb/sim_pte_pack_writer.sv
module sim_pte_pack_writer;
  localparam int IDX_W = 17, CNT_W = 18, PA_W = 40;
  localparam logic [PA_W-1:0] DUMMY = 40'h00_0ABC_D123;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, unmap = 1'b0, stream_mode = 1'b0;
  logic [IDX_W-1:0] first_idx = '0;
  logic [CNT_W-1:0] count = '0;
  logic [PA_W-1:0] lin_base = '0;
  logic src_valid, src_ready, mem_req, mem_we, mem_ack, busy, done;
  logic [PA_W-1:0] src_addr;
  logic [IDX_W+1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  pte_pack_writer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .unmap(unmap), .stream_mode(stream_mode),
    .first_idx(first_idx), .count(count), .lin_base(lin_base), .dummy_addr(DUMMY),
    .src_valid(src_valid), .src_addr(src_addr), .src_ready(src_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done));

  int checks = 0, fails = 0;
  logic [31:0] mem [1024];
  logic [31:0] refw [1024];
  int rd_n = 0, wr_n = 0, sp = 0, seed = 0;
  logic clr = 1'b0, strm_on = 1'b0, ack_r = 1'b0;
  logic [31:0] rdata_r = '0;
  logic [1:0] cyc = '0;

  function automatic logic [PA_W-1:0] saddr(int s, int k);
    return (PA_W'(s + k + 1) * 40'h12_3456_7ABC) ^ 40'h5A_A5A5_A5A5;
  endfunction

  assign mem_ack   = ack_r;
  assign mem_rdata = rdata_r;
  assign src_valid = strm_on && (cyc != 2'd0);
  assign src_addr  = saddr(seed, sp);

  always @(posedge clk) begin
    cyc <= cyc + 2'd1;
    if (clr) begin
      rd_n <= 0; wr_n <= 0; sp <= 0; ack_r <= 1'b0;
    end else begin
      if (src_valid && src_ready) sp <= sp + 1;
      if (mem_req && !ack_r) begin
        ack_r <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[11:2]] <= mem_wdata;
          wr_n <= wr_n + 1;
        end else begin
          rdata_r <= mem[mem_addr[11:2]];
          rd_n <= rd_n + 1;
        end
      end else ack_r <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int g, input int s, input logic [26:0] p);
    case (s)
      0: refw[4*g][26:0] = p;
      1: begin refw[4*g][31:27] = p[4:0];   refw[4*g+1][21:0] = p[26:5];  end
      2: begin refw[4*g+1][31:22] = p[9:0]; refw[4*g+2][16:0] = p[26:10]; end
      default: begin refw[4*g+2][31:17] = p[14:0]; refw[4*g+3][11:0] = p[26:15]; end
    endcase
  endtask

  task automatic model(input bit um, input bit st, input int i0, input int cnt,
                       input logic [PA_W-1:0] base, output int erd, output int ewr);
    int i = i0, rem = cnt, k = 0;
    erd = 0; ewr = 0;
    while (rem > 0) begin
      int lo = i % 4;
      int n = (rem < 4 - lo) ? rem : 4 - lo;
      int g = i / 4;
      bit full = (lo == 0) && (um ? rem > 4 : rem >= 4);
      if (full && um) begin
        for (int w = 0; w < 4; w++) refw[4*g+w] = '0;
      end else begin
        if (full) for (int w = 0; w < 4; w++) refw[4*g+w] = '0;
        else erd += 4;
        for (int j = 0; j < n; j++) begin
          logic [PA_W-1:0] a;
          a = um ? DUMMY : st ? saddr(seed, k) : base + PA_W'(k) * 40'h1000;
          put(g, lo + j, a[38:12]);
          k++;
        end
        refw[4*g+3][30] = 1'b1;
      end
      ewr += 4; i += n; rem -= n;
    end
  endtask

  task automatic run(input bit um, input bit st, input int i0, input int cnt,
                     input logic [PA_W-1:0] base, input string tag);
    int erd, ewr, bad = 0, first_bad = -1, waited = 0;
    model(um, st, i0, cnt, base, erd, ewr);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    unmap = um; stream_mode = st; strm_on = st;
    first_idx = IDX_W'(i0); count = CNT_W'(cnt); lin_base = base; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && waited < 5000) begin @(negedge clk); waited++; end
    check(done == 1'b1, {tag, " R9 done reached"}, 64'(done), 64'd1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, {tag, " R9 done one cycle"}, 64'({done, busy}), 64'd0);
    strm_on = 1'b0;
    for (int w = 0; w < 256; w++) if (mem[w] !== refw[w]) begin
      bad++; if (first_bad < 0) first_bad = w;
    end
    if (first_bad < 0) first_bad = 0;
    check(bad == 0, {tag, " R1 R3 R4 R5 R6 R11 table contents"},
          {32'(first_bad), mem[first_bad]}, {32'(first_bad), refw[first_bad]});
    check(rd_n == erd, {tag, " R3 R4 R5 read count"}, 64'(rd_n), 64'(erd));
    check(wr_n == ewr, {tag, " R2 R11 write count"}, 64'(wr_n), 64'(ewr));
    if (st) check(sp == cnt, {tag, " R7 stream addresses taken"}, 64'(sp), 64'(cnt));
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // {unmap, stream, idx[11:0], cnt[11:0]}
  localparam logic [25:0] VEC [10] = '{
    {2'b00, 12'd0,  12'd4},
    {2'b00, 12'd5,  12'd2},
    {2'b00, 12'd6,  12'd11},
    {2'b01, 12'd16, 12'd7},
    {2'b01, 12'd33, 12'd3},
    {2'b10, 12'd6,  12'd11},
    {2'b10, 12'd40, 12'd4},
    {2'b10, 12'd48, 12'd9},
    {2'b00, 12'd3,  12'd1},
    {2'b00, 12'd64, 12'd12}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int w = 0; w < 1024; w++) begin
      mem[w] = 32'hA500_0000 ^ (32'(w) * 32'h9E37_79B1);
      refw[w] = mem[w];
    end
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0 && src_ready == 1'b0,
          "R9 reset state", 64'({busy, done, mem_req, src_ready}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 10; r++) begin
      logic [PA_W-1:0] base;
      seed = r * 37;
      base = (r == 9) ? 40'h7F_FFFF_E000 : 40'h12_3456_7000 + PA_W'(r) * 40'h10_0000;
      run(VEC[r][25], VEC[r][24], int'(VEC[r][23:12]), int'(VEC[r][11:0]), base,
          $sformatf("vec%0d", r));
    end

    // R8: zero count
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    count = '0; first_idx = IDX_W'(9); unmap = 1'b0; stream_mode = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b1 && mem_req == 1'b0, "R8 zero count done", 64'({done, mem_req}), 64'b10);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8 zero count idle", 64'({done, busy}), 64'd0);
    check(rd_n == 0 && wr_n == 0, "R8 zero count traffic", 64'(rd_n + wr_n), 64'd0);

    // R5: unmap run starting mid-group and ending exactly on an aligned group of four
    seed = 0;
    run(1'b1, 1'b0, 101, 7, '0, "r5_mid_tail4");
    // R6/R3: single entry in slot 2 under linear mode
    run(1'b0, 1'b0, 130, 1, 40'h00_0000_1FFF, "r6_single");

    summary();
    $finish;
  end
endmodule